// File: doc/BRIEF.md
# Two-Half Receive Block FIFO

This block holds received bytes between a serial frame receiver and a host. The host may be a CPU or a DMA engine. The store has room for 64 bytes, split into two banks of 32. The receiver writes each incoming byte into whichever bank is currently being filled. The host sees exactly one bank, called the accessible bank, through a combinational read port. Once the accessible bank holds 32 bytes, the block raises a request: an interrupt flag in interrupt mode, or a DMA request line in DMA mode.

Reading the accessible bank never removes data. The bank is released only by an acknowledge. In interrupt mode the acknowledge is an explicit command strobe. In DMA mode it happens by itself on the 32nd counted read. After the release, the freed bank takes new bytes again and the other bank becomes accessible. A frame of up to 64 bytes therefore fits whole. If both banks are full and unacknowledged, bytes that arrive are discarded and a sticky overflow flag is raised.

Top module: `rxq_two_bank`

## Requirements
- R1: After reset both banks are empty, `poolIrq`, `dmaReq` and `overflow` are 0, and the accessible bank is the one that fills first.
- R2: A request appears only once the accessible bank holds 32 bytes. After 31 writes it is still low. It is high in the cycle after the clock edge that stores the 32nd byte.
- R3: `rdData` shows, combinationally, the byte at offset `rdAddr` (0 to 31, offset 0 being the first byte written to that bank) of the accessible bank. Reading the bank any number of times leaves its data and the request unchanged.
- R4: In interrupt mode (`dmaMode`=0), an `ackCmd` taken while `poolIrq` is high does the following at that clock edge: it frees the accessible bank, moves access to the other bank and clears `overflow`. `poolIrq` drops in the next cycle unless the other bank is already full.
- R5: `ackCmd` has no effect while no request is pending, and no effect at all in DMA mode.
- R6: In DMA mode the request appears on `dmaReq` and `poolIrq` stays 0. `rdAddr` is ignored. Each `rdEn` while `dmaReq` is high advances an internal offset starting at 0, and `rdData` shows the byte at that offset. The 32nd such read acknowledges the bank implicitly, and `dmaReq` is low in the next cycle unless the other bank is full.
- R7: Once the first bank fills, further bytes go into the other bank. All 64 bytes of a 64-byte frame are kept, and after the first acknowledge the second 32 are readable at offsets 0 to 31.
- R8: A byte written while both banks are full is discarded. `overflow` goes to 1 in the next cycle and stays 1 until the next acknowledge. The discarded byte never appears on `rdData`.
- R9: If the newly accessible bank is already full when an acknowledge is taken, the request stays asserted through the hand-over. Otherwise the request returns once that bank fills.
- R10: `rdEn` has no effect in interrupt mode. In DMA mode it has no effect while no request is pending, so the DMA offset is still 0 when the next bank fills.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| dmaMode | input | 1 | 1 selects DMA acknowledge mode, 0 selects interrupt mode |
| wrValid | input | 1 | Receiver byte strobe |
| wrData | input | DATA_W | Received byte |
| rdEn | input | 1 | Host read strobe (counted in DMA mode only) |
| rdAddr | input | 5 | Offset within the accessible bank (interrupt mode) |
| ackCmd | input | 1 | Explicit acknowledge command strobe (interrupt mode) |
| rdData | output | DATA_W | Byte at the selected offset of the accessible bank |
| poolIrq | output | 1 | Accessible bank full, interrupt mode |
| dmaReq | output | 1 | Accessible bank full, DMA mode |
| overflow | output | 1 | Sticky flag: a byte was discarded since the last acknowledge |

## Verification
The checker assumes that `dmaMode` changes only while no request is pending. It also assumes that `rdAddr` is held steady whenever the bench compares `rdData` across cycles. The read-stability property compares `rdData` only across cycles in which the mode, the address and the pending request are all unchanged and no acknowledge was issued. The bench switches mode only after the accessible bank has been released. It drives every strobe for exactly one cycle, on the falling edge, so each acknowledge, write or read that the checker sees is a single deliberate event.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int HALF_DEPTH = 32;
  localparam int NUM_BANKS  = 2;
  localparam int IDX_W      = $clog2(HALF_DEPTH);
  localparam int CNT_W      = $clog2(HALF_DEPTH + 1);

  typedef struct packed {
    logic             memWe;
    logic             wrBank;
    logic [IDX_W-1:0] wrIdx;
    logic             rdBank;
    logic [IDX_W-1:0] rdIdx;
  } rxqStrobe_t;
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             dmaMode,
  input  logic             wrValid,
  input  logic             rdEn,
  input  logic [IDX_W-1:0] rdAddr,
  input  logic             ackCmd,
  output rxqStrobe_t       strobe,
  output logic             poolIrq,
  output logic             dmaReq,
  output logic             overflow
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(HALF_DEPTH);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HALF_DEPTH - 1);

  logic [CNT_W-1:0] fillCnt [NUM_BANKS];
  logic             wrBank;
  logic             accBank;
  logic [IDX_W-1:0] dmaIdx;
  logic             ovfFlag;

  logic accFull, wrRoom, wrTake, wrDrop;
  logic ackInt, ackDma, ackTake, wrLast;

  always_comb begin
    accFull = (fillCnt[accBank] == FULL_CNT);
    wrRoom  = (fillCnt[wrBank] != FULL_CNT);
    wrTake  = wrValid && wrRoom;
    wrDrop  = wrValid && !wrRoom;
    wrLast  = wrTake && (fillCnt[wrBank] == FULL_CNT - 1'b1);
    ackInt  = !dmaMode && ackCmd && accFull;
    ackDma  = dmaMode && rdEn && accFull && (dmaIdx == LAST_IDX);
    ackTake = ackInt || ackDma;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_fill
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        fillCnt[b] <= '0;
      end else if (ackTake && (accBank == 1'(b))) begin
        fillCnt[b] <= '0;
      end else if (wrTake && (wrBank == 1'(b))) begin
        fillCnt[b] <= fillCnt[b] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrBank  <= 1'b0;
      accBank <= 1'b0;
      dmaIdx  <= '0;
      ovfFlag <= 1'b0;
    end else begin
      if (wrLast) wrBank <= ~wrBank;
      if (ackTake) accBank <= ~accBank;
      if (!dmaMode) begin
        dmaIdx <= '0;
      end else if (rdEn && accFull) begin
        dmaIdx <= ackDma ? '0 : dmaIdx + 1'b1;
      end
      if (wrDrop) begin
        ovfFlag <= 1'b1;
      end else if (ackTake) begin
        ovfFlag <= 1'b0;
      end
    end
  end

  always_comb begin
    strobe.memWe  = wrTake;
    strobe.wrBank = wrBank;
    strobe.wrIdx  = fillCnt[wrBank][IDX_W-1:0];
    strobe.rdBank = accBank;
    strobe.rdIdx  = dmaMode ? dmaIdx : rdAddr;
  end

  assign poolIrq  = accFull && !dmaMode;
  assign dmaReq   = accFull && dmaMode;
  assign overflow = ovfFlag;
endmodule

// File: rtl/rxq_datapath.sv
module rxq_datapath
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  rxqStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] bankOut [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] store [HALF_DEPTH];

    always_ff @(posedge clk) begin
      if (strobe.memWe && (strobe.wrBank == 1'(b))) begin
        store[strobe.wrIdx] <= wrData;
      end
    end

    assign bankOut[b] = store[strobe.rdIdx];
  end

  assign rdData = bankOut[strobe.rdBank];
endmodule

// File: rtl/rxq_two_bank.sv
module rxq_two_bank
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dmaMode,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [IDX_W-1:0]  rdAddr,
  input  logic              ackCmd,
  output logic [DATA_W-1:0] rdData,
  output logic              poolIrq,
  output logic              dmaReq,
  output logic              overflow
);
  rxqStrobe_t strobe;

  rxq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .dmaMode  (dmaMode),
    .wrValid  (wrValid),
    .rdEn     (rdEn),
    .rdAddr   (rdAddr),
    .ackCmd   (ackCmd),
    .strobe   (strobe),
    .poolIrq  (poolIrq),
    .dmaReq   (dmaReq),
    .overflow (overflow)
  );

  rxq_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .strobe (strobe),
    .wrData (wrData),
    .rdData (rdData)
  );
endmodule

// File: rtl/rxq_two_bank_chk.sv
module rxq_two_bank_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              dmaMode,
  input logic              wrValid,
  input logic              rdEn,
  input logic [4:0]        rdAddr,
  input logic              ackCmd,
  input logic [DATA_W-1:0] rdData,
  input logic              poolIrq,
  input logic              dmaReq,
  input logic              overflow
);
  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  // R6: only one request line, chosen by mode
  assert_req_mode_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(poolIrq && dmaReq) && !(dmaMode && poolIrq) && !(!dmaMode && dmaReq));

  // R8: overflow only rises after a write arriving while a bank was pending
  assert_ovf_cause_R8: assert property (@(posedge clk) disable iff (!rstN || !armed)
    $rose(overflow) |-> ($past(wrValid) && $past(poolIrq || dmaReq)));

  // R4: an explicit acknowledge without a concurrent write clears overflow
  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!dmaMode && ackCmd && poolIrq && !wrValid) |=> !overflow);

  // R2, R9: a request rises only after a write or an acknowledge
  assert_req_rise_R2: assert property (@(posedge clk) disable iff (!rstN || !armed)
    $rose(poolIrq || dmaReq) |-> ($past(wrValid) || $past(ackCmd) || $past(rdEn)));

  // R3: reading leaves the accessible bank unchanged
  assert_read_stable_R3: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (!dmaMode && !$past(dmaMode) && poolIrq && $past(poolIrq) && !$past(ackCmd)
      && $stable(rdAddr)) |-> $stable(rdData));
endmodule

bind rxq_two_bank rxq_two_bank_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .dmaMode  (dmaMode),
  .wrValid  (wrValid),
  .rdEn     (rdEn),
  .rdAddr   (rdAddr),
  .ackCmd   (ackCmd),
  .rdData   (rdData),
  .poolIrq  (poolIrq),
  .dmaReq   (dmaReq),
  .overflow (overflow)
);

// File: tb/sim_rxq_two_bank.sv
module sim_rxq_two_bank;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       dmaMode = 1'b0;
  logic       wrValid = 1'b0;
  logic [7:0] wrData = '0;
  logic       rdEn = 1'b0;
  logic [4:0] rdAddr = '0;
  logic       ackCmd = 1'b0;
  logic [7:0] rdData;
  logic       poolIrq, dmaReq, overflow;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  rxq_two_bank u0 (
    .clk(clk), .rstN(rstN), .dmaMode(dmaMode), .wrValid(wrValid),
    .wrData(wrData), .rdEn(rdEn), .rdAddr(rdAddr), .ackCmd(ackCmd),
    .rdData(rdData), .poolIrq(poolIrq), .dmaReq(dmaReq), .overflow(overflow)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
    end
  endtask

  task automatic putByte(input logic [7:0] v);
    @(negedge clk);
    wrValid = 1'b1; wrData = v;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic putBlock(input logic [7:0] base, input int n);
    for (int i = 0; i < n; i++) putByte(base + 8'(i));
  endtask

  task automatic pulseAck();
    @(negedge clk); ackCmd = 1'b1;
    @(negedge clk); ackCmd = 1'b0;
  endtask

  task automatic pulseRd();
    @(negedge clk); rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic peek(input logic [4:0] a, output logic [7:0] v);
    @(negedge clk); rdAddr = a;
    #1 v = rdData;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 poolIrq", int'(poolIrq), 0);
    check("R1 dmaReq", int'(dmaReq), 0);
    check("R1 overflow", int'(overflow), 0);
  endtask

  task automatic t_fill_first();
    pulseAck();
    check("R5 ack idle", int'(poolIrq), 0);
    putBlock(8'h00, 31);
    check("R2 31 bytes", int'(poolIrq), 0);
    putByte(8'h1F);
    check("R2 32 bytes", int'(poolIrq), 1);
  endtask

  task automatic t_reread();
    logic [7:0] v;
    for (int rep = 0; rep < 2; rep++) begin
      peek(5'd0, v);  check("R3 offset 0", int'(v), 8'h00);
      peek(5'd31, v); check("R3 offset 31", int'(v), 8'h1F);
      peek(5'd5, v);  check("R3 offset 5", int'(v), 8'h05);
    end
    pulseRd(); pulseRd();
    peek(5'd0, v);
    check("R10 rdEn interrupt data", int'(v), 8'h00);
    check("R3 request kept", int'(poolIrq), 1);
  endtask

  task automatic t_second_and_overflow();
    logic [7:0] v;
    putBlock(8'h40, 32);
    check("R7 still pending", int'(poolIrq), 1);
    check("R7 no overflow", int'(overflow), 0);
    putByte(8'hEE);
    check("R8 overflow set", int'(overflow), 1);
    putByte(8'hEF);
    check("R8 overflow sticky", int'(overflow), 1);
    peek(5'd3, v);
    check("R8 first bank intact", int'(v), 8'h03);
  endtask

  task automatic t_ack_handover();
    logic [7:0] v;
    pulseAck();
    check("R9 request held", int'(poolIrq), 1);
    check("R4 overflow cleared", int'(overflow), 0);
    peek(5'd0, v);  check("R7 second block offset 0", int'(v), 8'h40);
    peek(5'd31, v); check("R8 no dropped byte", int'(v), 8'h5F);
    pulseAck();
    check("R4 request released", int'(poolIrq), 0);
    putBlock(8'h80, 5);
    check("R9 partial no request", int'(poolIrq), 0);
    putBlock(8'h85, 27);
    check("R9 request returns", int'(poolIrq), 1);
    peek(5'd0, v); check("R4 new block offset 0", int'(v), 8'h80);
    pulseAck();
    check("R4 third ack", int'(poolIrq), 0);
  endtask

  task automatic t_dma();
    logic [7:0] v;
    @(negedge clk); dmaMode = 1'b1;
    pulseRd(); pulseRd(); pulseRd();
    putBlock(8'hA0, 32);
    check("R6 dmaReq", int'(dmaReq), 1);
    check("R6 poolIrq quiet", int'(poolIrq), 0);
    #1 check("R10 dma idle reads", int'(rdData), 8'hA0);
    pulseAck();
    check("R5 ack in dma", int'(dmaReq), 1);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk); rdAddr = 5'd31;
      #1 v = rdData;
      check("R6 dma stream", int'(v), 8'hA0 + i);
      if (i == 31) check("R6 before last", int'(dmaReq), 1);
      pulseRd();
    end
    check("R6 implicit ack", int'(dmaReq), 0);
    putBlock(8'hC0, 32);
    #1 check("R6 next block offset 0", int'(rdData), 8'hC0);
    for (int i = 0; i < 32; i++) pulseRd();
    check("R6 second implicit ack", int'(dmaReq), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_fill_first();
    t_reread();
    t_second_and_overflow();
    t_ack_handover();
    t_dma();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule